// File: doc/BRIEF.md
# Secure JTAG Instruction Decoder

This block is a test access port controller with a 10-bit instruction register. It walks the standard 16-state TAP sequence on rising TCK, decodes the instruction loaded at Update-IR, and picks the data register placed between TDI and TDO. The choices are a 1-bit bypass cell, a 32-bit word register, or a boundary-scan chain of parameterised length. The word register reads from one of three sources: the identification code, the user signature, or an error-status word. Configuration and key-management instructions do not shift data. They produce a one-cycle decoded strobe for logic that lives outside this block.

The block also keeps a secure mode. Lock and unlock opcodes act only when a core-side access flag is high at Update-IR. The same opcodes shifted in from the external pins are dropped. While secure mode is on, a short list of instructions keeps working and every other opcode falls back to bypass. The flag survives Test-Logic-Reset and is cleared only by the power-on reset.

The port has no streaming data, so no valid/ready handshake applies and there is no back-pressure. Every pin is a plain level or strobe. TDI and TMS are sampled on rising TCK. TDO and its enable change on falling TCK.

Top module: `jtag_secure_tap`

## Requirements
- R1: After rst_n, and after any rising TCK in Test-Logic-Reset, the active instruction is IDCODE. A Shift-DR then returns the 32-bit IDCODE_VAL parameter, LSB first, with no instruction loaded.
- R2: Capture-IR loads 10'b0000000001, which is shifted out LSB first during Shift-IR. A shifted opcode takes effect only on the rising TCK in Update-IR.
- R3: Opcode 10'h3FF (BYPASS) selects a 1-bit register that captures 0. Shifted data appears on TDO delayed by exactly one shift.
- R4: Opcode 10'h007 selects the 32-bit usercode input. Opcode 10'h017 selects the 32-bit err_word input. Each is loaded in Capture-DR and shifted out LSB first.
- R5: Opcode 10'h005 (sample/preload) and opcode 10'h00F (external test) both select the boundary chain. The chain captures pin_in in Capture-DR, bit 0 nearest TDO, and loads bsr_drive at Update-DR. bsr_drive_en is high only under external test or clamp.
- R6: Opcode 10'h00B raises highz_all. Opcode 10'h00A raises bsr_drive_en with highz_all low. Both opcodes use the 1-bit bypass path.
- R7: Opcodes 10'h001, 10'h029 and 10'h013 raise reconfig_stb, key_clear_stb and key_verify_stb respectively. The strobe lasts one TCK cycle, starting after the Update-IR edge. At most one strobe is high at a time.
- R8: Opcode 10'h00D raises config_io_stb only if status_ready is high at the Update-IR edge. Otherwise the opcode acts as bypass.
- R9: Opcode 10'h1F0 enters secure mode only when core_access is high at Update-IR. From the pins it changes nothing and acts as bypass.
- R10: In secure mode only bypass, sample/preload, external test, IDCODE, error read and unlock are honoured. Every other opcode acts as bypass, so it raises no strobe, no highz_all and no bsr_drive_en.
- R11: Opcode 10'h331 leaves secure mode only when core_access is high. Secure mode persists through Test-Logic-Reset.
- R12: Any undefined opcode acts as bypass.
- R13: TDO changes on falling TCK. tdo_en is high only for the falling edges that occur in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable |
| core_access | input | 1 | High when the instruction comes through the core-side path |
| status_ready | input | 1 | Permits the I/O reconfiguration instruction |
| usercode | input | 32 | User signature word |
| err_word | input | 32 | Error-status word |
| pin_in | input | BSR_LEN | Pin values captured by the boundary chain |
| bsr_drive | output | BSR_LEN | Boundary update register |
| bsr_drive_en | output | 1 | Pins driven from bsr_drive |
| highz_all | output | 1 | Tristate all user pins |
| reconfig_stb | output | 1 | Reconfiguration strobe |
| config_io_stb | output | 1 | I/O reconfiguration strobe |
| key_clear_stb | output | 1 | Volatile key clear strobe |
| key_verify_stb | output | 1 | Key verify strobe |

## Verification
The bench issues lock and unlock twice each, once from the pins and once with core_access high. A design that trusted pin-side lock would block highz_all afterwards. A design that trusted pin-side unlock would restore it too early. Secure mode is then driven through Test-Logic-Reset, which catches a design that clears the flag there. Blocked, undefined, clamp and tristate opcodes are all checked for a one-bit bypass delay, so a design that leaves a wider register in the chain shows shifted-off data. The I/O reconfiguration strobe is tried with status_ready both low and high, and each strobe is counted to catch a wrong width or a strobe firing on a dropped opcode.

// File: rtl/jtag_sec_pkg.sv
package jtag_sec_pkg;

  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [3:0] {
    I_BYPASS, I_IDCODE, I_USERCODE, I_ERRREAD, I_SAMPLE, I_EXTEST,
    I_HIGHZ, I_CLAMP, I_RECONFIG, I_CFGIO, I_KEYCLR, I_KEYVFY
  } instr_e;

  typedef enum logic [1:0] {DR_BYP, DR_WORD, DR_BSR} dr_sel_e;

  localparam logic [IR_W-1:0] OP_BYPASS   = '1;
  localparam logic [IR_W-1:0] OP_IDCODE   = 10'h006;
  localparam logic [IR_W-1:0] OP_USERCODE = 10'h007;
  localparam logic [IR_W-1:0] OP_ERRREAD  = 10'h017;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 10'h005;
  localparam logic [IR_W-1:0] OP_EXTEST   = 10'h00F;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 10'h00B;
  localparam logic [IR_W-1:0] OP_CLAMP    = 10'h00A;
  localparam logic [IR_W-1:0] OP_RECONFIG = 10'h001;
  localparam logic [IR_W-1:0] OP_CFGIO    = 10'h00D;
  localparam logic [IR_W-1:0] OP_KEYCLR   = 10'h029;
  localparam logic [IR_W-1:0] OP_KEYVFY   = 10'h013;
  localparam logic [IR_W-1:0] OP_LOCK     = 10'h1F0;
  localparam logic [IR_W-1:0] OP_UNLOCK   = 10'h331;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 10'b0000000001;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  function automatic logic secure_ok(instr_e i);
    return (i == I_BYPASS) || (i == I_IDCODE) || (i == I_ERRREAD) ||
           (i == I_SAMPLE) || (i == I_EXTEST);
  endfunction

  function automatic dr_sel_e dr_of(instr_e i);
    case (i)
      I_IDCODE, I_USERCODE, I_ERRREAD: return DR_WORD;
      I_SAMPLE, I_EXTEST:              return DR_BSR;
      default:                         return DR_BYP;
    endcase
  endfunction

endpackage

// File: rtl/jtag_sec_fsm.sv
module jtag_sec_fsm
  import jtag_sec_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/jtag_sec_ir.sv
module jtag_sec_ir
  import jtag_sec_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       core_access,
  input  logic       status_ready,
  output logic       ir_lsb,
  output instr_e     active,
  output logic       locked,
  output logic       fresh
);

  logic [IR_W-1:0] ir_sr;
  instr_e          cand;
  instr_e          granted;
  logic            lock_set;
  logic            lock_clr;

  // shift path: capture pattern, then shift toward bit 0
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_SHF_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  assign ir_lsb = ir_sr[0];

  // opcode decode; lock requests count only from the core side
  always_comb begin
    cand     = I_BYPASS;
    lock_set = 1'b0;
    lock_clr = 1'b0;
    case (ir_sr)
      OP_IDCODE:   cand = I_IDCODE;
      OP_USERCODE: cand = I_USERCODE;
      OP_ERRREAD:  cand = I_ERRREAD;
      OP_SAMPLE:   cand = I_SAMPLE;
      OP_EXTEST:   cand = I_EXTEST;
      OP_HIGHZ:    cand = I_HIGHZ;
      OP_CLAMP:    cand = I_CLAMP;
      OP_RECONFIG: cand = I_RECONFIG;
      OP_CFGIO:    cand = status_ready ? I_CFGIO : I_BYPASS;
      OP_KEYCLR:   cand = I_KEYCLR;
      OP_KEYVFY:   cand = I_KEYVFY;
      OP_LOCK:     lock_set = core_access;
      OP_UNLOCK:   lock_clr = core_access;
      default:     cand = I_BYPASS;
    endcase
  end

  assign granted = (locked && !secure_ok(cand)) ? I_BYPASS : cand;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      active <= I_IDCODE;
      locked <= 1'b0;
      fresh  <= 1'b0;
    end else begin
      fresh <= (state == ST_UPD_IR);
      if (state == ST_TLR) begin
        active <= I_IDCODE;
      end else if (state == ST_UPD_IR) begin
        active <= granted;
        if (lock_set)      locked <= 1'b1;
        else if (lock_clr) locked <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/jtag_sec_dr.sv
module jtag_sec_dr
  import jtag_sec_pkg::*;
#(
  parameter int          WORD_W     = 32,
  parameter int          BSR_LEN    = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1234_50DD
)(
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  logic               tdi,
  input  instr_e             active,
  input  logic [WORD_W-1:0]  usercode,
  input  logic [WORD_W-1:0]  err_word,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_upd
);

  localparam logic [WORD_W-1:0] ID_WORD = WORD_W'(IDCODE_VAL);

  dr_sel_e             sel;
  logic                byp_q;
  logic [WORD_W-1:0]   word_sr;
  logic [WORD_W-1:0]   word_src;
  logic [BSR_LEN-1:0]  bsr_sr;

  assign sel = dr_of(active);

  always_comb begin
    case (active)
      I_IDCODE:   word_src = ID_WORD;
      I_USERCODE: word_src = usercode;
      default:    word_src = err_word;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q   <= 1'b0;
      word_sr <= '0;
      bsr_sr  <= '0;
      bsr_upd <= '0;
    end else begin
      case (state)
        ST_CAP_DR: begin
          case (sel)
            DR_WORD: word_sr <= word_src;
            DR_BSR:  bsr_sr  <= pin_in;
            default: byp_q   <= 1'b0;
          endcase
        end
        ST_SHF_DR: begin
          case (sel)
            DR_WORD: word_sr <= {tdi, word_sr[WORD_W-1:1]};
            DR_BSR:  bsr_sr  <= {tdi, bsr_sr[BSR_LEN-1:1]};
            default: byp_q   <= tdi;
          endcase
        end
        ST_UPD_DR: begin
          if (sel == DR_BSR) bsr_upd <= bsr_sr;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DR_WORD: dr_lsb = word_sr[0];
      DR_BSR:  dr_lsb = bsr_sr[0];
      default: dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/jtag_secure_tap.sv
module jtag_secure_tap
  import jtag_sec_pkg::*;
#(
  parameter int          BSR_LEN    = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1234_50DD
)(
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic               core_access,
  input  logic               status_ready,
  input  logic [31:0]        usercode,
  input  logic [31:0]        err_word,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] bsr_drive,
  output logic               bsr_drive_en,
  output logic               highz_all,
  output logic               reconfig_stb,
  output logic               config_io_stb,
  output logic               key_clear_stb,
  output logic               key_verify_stb
);

  tap_state_e state;
  instr_e     active;
  logic       locked;
  logic       fresh;
  logic       ir_lsb;
  logic       dr_lsb;

  jtag_sec_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  jtag_sec_ir u_ir (
    .tck          (tck),
    .rst_n        (rst_n),
    .state        (state),
    .tdi          (tdi),
    .core_access  (core_access),
    .status_ready (status_ready),
    .ir_lsb       (ir_lsb),
    .active       (active),
    .locked       (locked),
    .fresh        (fresh)
  );

  jtag_sec_dr #(
    .WORD_W     (32),
    .BSR_LEN    (BSR_LEN),
    .IDCODE_VAL (IDCODE_VAL)
  ) u_dr (
    .tck      (tck),
    .rst_n    (rst_n),
    .state    (state),
    .tdi      (tdi),
    .active   (active),
    .usercode (usercode),
    .err_word (err_word),
    .pin_in   (pin_in),
    .dr_lsb   (dr_lsb),
    .bsr_upd  (bsr_drive)
  );

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      if (state == ST_SHF_IR)      tdo <= ir_lsb;
      else if (state == ST_SHF_DR) tdo <= dr_lsb;
    end
  end

  assign highz_all      = (active == I_HIGHZ);
  assign bsr_drive_en   = (active == I_EXTEST) || (active == I_CLAMP);
  assign reconfig_stb   = fresh && (active == I_RECONFIG);
  assign config_io_stb  = fresh && (active == I_CFGIO);
  assign key_clear_stb  = fresh && (active == I_KEYCLR);
  assign key_verify_stb = fresh && (active == I_KEYVFY);

endmodule

// File: rtl/jtag_secure_tap_chk.sv
module jtag_secure_tap_chk
  import jtag_sec_pkg::*;
(
  input logic       tck,
  input logic       rst_n,
  input tap_state_e state,
  input instr_e     active,
  input logic       locked,
  input logic       core_access,
  input logic       status_ready,
  input logic       highz_all,
  input logic       bsr_drive_en,
  input logic       reconfig_stb,
  input logic       config_io_stb,
  input logic       key_clear_stb,
  input logic       key_verify_stb
);

  assert_tlr_idcode_R1: assert property (@(posedge tck) disable iff (!rst_n)
    state == ST_TLR |=> active == I_IDCODE);

  assert_update_only_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(active));

  assert_tristate_no_drive_R6: assert property (@(posedge tck) disable iff (!rst_n)
    !(highz_all && bsr_drive_en));

  assert_single_strobe_R7: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({reconfig_stb, config_io_stb, key_clear_stb, key_verify_stb}));

  assert_cfgio_ready_R8: assert property (@(posedge tck) disable iff (!rst_n)
    config_io_stb |-> $past(status_ready));

  assert_pin_lock_ignored_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_IR && !core_access) |=> $stable(locked));

  assert_secure_subset_R10: assert property (@(posedge tck) disable iff (!rst_n)
    locked |-> secure_ok(active));

  assert_lock_holds_R11: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR) |=> $stable(locked));

endmodule

bind jtag_secure_tap jtag_secure_tap_chk u_chk (
  .tck            (tck),
  .rst_n          (rst_n),
  .state          (state),
  .active         (active),
  .locked         (locked),
  .core_access    (core_access),
  .status_ready   (status_ready),
  .highz_all      (highz_all),
  .bsr_drive_en   (bsr_drive_en),
  .reconfig_stb   (reconfig_stb),
  .config_io_stb  (config_io_stb),
  .key_clear_stb  (key_clear_stb),
  .key_verify_stb (key_verify_stb)
);

// File: tb/jtag_secure_tap_tb.sv
`timescale 1ns/1ps
module jtag_secure_tap_tb;

  localparam int          BL  = 8;
  localparam logic [31:0] ID  = 32'h4A5C_10E3;
  localparam logic [31:0] UC  = 32'hC0DE_0A5A;
  localparam logic [31:0] EW  = 32'h0BAD_F00D;
  localparam logic [BL-1:0] PINS = 8'hA5;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0;
  logic core_access = 1'b0, status_ready = 1'b0;
  logic tdo, tdo_en, bsr_drive_en, highz_all;
  logic reconfig_stb, config_io_stb, key_clear_stb, key_verify_stb;
  logic [BL-1:0] bsr_drive;

  int checks = 0, errors = 0;
  int n_rc = 0, n_ci = 0, n_kc = 0, n_kv = 0;
  logic last_oen;
  bit   done = 1'b0;

  always #2 tck = ~tck;

  jtag_secure_tap #(.BSR_LEN(BL), .IDCODE_VAL(ID)) u_dut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .core_access(core_access), .status_ready(status_ready),
    .usercode(UC), .err_word(EW), .pin_in(PINS),
    .bsr_drive(bsr_drive), .bsr_drive_en(bsr_drive_en), .highz_all(highz_all),
    .reconfig_stb(reconfig_stb), .config_io_stb(config_io_stb),
    .key_clear_stb(key_clear_stb), .key_verify_stb(key_verify_stb)
  );

  always @(negedge tck) begin
    if (reconfig_stb)   n_rc++;
    if (config_io_stb)  n_ci++;
    if (key_clear_stb)  n_kc++;
    if (key_verify_stb) n_kv++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one TCK cycle: drive before the rising edge, sample TDO from the last falling edge
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    tms = m; tdi = d;
    o = tdo; last_oen = tdo_en;
    @(posedge tck);
    #1;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic go_reset_idle();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
    logic o;
    bit en_ok = 1'b1;
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, op[i], o);
      cap[i] = o;
      if (!last_oen) en_ok = 1'b0;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    chk(en_ok, "R13 tdo_en in Shift-IR", 64'(en_ok), 64'd1);
    step(1'b0, 1'b0, o);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
  endtask

  task automatic expect_bypass(input string req);
    logic [63:0] r;
    shift_dr(8, 64'hB6, r);
    chk(r[7:0] == 8'h6C, req, r, 64'h6C);
  endtask

  task automatic t_reset();
    logic [63:0] r;
    logic o;
    chk(tdo_en == 1'b0 && highz_all == 1'b0 && bsr_drive_en == 1'b0, "R1 reset outputs",
        64'({tdo_en, highz_all, bsr_drive_en}), 64'd0);
    step(1'b0, 1'b0, o);
    chk(last_oen == 1'b0, "R13 tdo_en idle", 64'(last_oen), 64'd0);
    shift_dr(32, 64'h0, r);
    chk(r[31:0] == ID, "R1 IDCODE after reset", r, 64'(ID));
  endtask

  task automatic t_words();
    logic [9:0] c;
    logic [63:0] r;
    load_ir(10'h007, c);
    chk(c == 10'h001, "R2 capture-IR pattern", 64'(c), 64'h001);
    shift_dr(32, 64'h0, r);
    chk(r[31:0] == UC, "R4 usercode", r, 64'(UC));
    load_ir(10'h017, c);
    shift_dr(32, 64'h0, r);
    chk(r[31:0] == EW, "R4 error word", r, 64'(EW));
  endtask

  task automatic t_bypass();
    logic [9:0] c;
    load_ir(10'h3FF, c);
    expect_bypass("R3 bypass one-bit delay");
    load_ir(10'h2AA, c);
    expect_bypass("R12 undefined acts as bypass");
    chk(!highz_all && !bsr_drive_en, "R12 undefined no side effect",
        64'({highz_all, bsr_drive_en}), 64'd0);
  endtask

  task automatic t_boundary();
    logic [9:0] c;
    logic [63:0] r;
    load_ir(10'h005, c);
    shift_dr(BL, 64'h3C, r);
    chk(r[BL-1:0] == PINS, "R5 sample captures pins", r, 64'(PINS));
    chk(bsr_drive == 8'h3C && !bsr_drive_en, "R5 preload updates, no drive",
        64'({bsr_drive_en, bsr_drive}), 64'h3C);
    load_ir(10'h00F, c);
    chk(bsr_drive_en && bsr_drive == 8'h3C, "R5 extest drives preload",
        64'({bsr_drive_en, bsr_drive}), 64'h13C);
    shift_dr(BL, 64'h81, r);
    chk(bsr_drive == 8'h81, "R5 extest update", 64'(bsr_drive), 64'h81);
  endtask

  task automatic t_hz_clamp();
    logic [9:0] c;
    load_ir(10'h00B, c);
    chk(highz_all && !bsr_drive_en, "R6 highz", 64'({highz_all, bsr_drive_en}), 64'h2);
    expect_bypass("R6 highz bypass path");
    load_ir(10'h00A, c);
    chk(!highz_all && bsr_drive_en, "R6 clamp", 64'({highz_all, bsr_drive_en}), 64'h1);
    expect_bypass("R6 clamp bypass path");
  endtask

  task automatic t_strobes();
    logic [9:0] c;
    n_rc = 0; n_ci = 0; n_kc = 0; n_kv = 0;
    load_ir(10'h001, c);
    chk(n_rc == 1 && n_ci == 0 && n_kc == 0 && n_kv == 0, "R7 reconfig strobe",
        64'({n_rc[7:0], n_ci[7:0], n_kc[7:0], n_kv[7:0]}), 64'h01000000);
    load_ir(10'h029, c);
    chk(n_kc == 1, "R7 key clear strobe", 64'(n_kc), 64'd1);
    load_ir(10'h013, c);
    chk(n_kv == 1 && n_rc == 1, "R7 key verify strobe", 64'(n_kv), 64'd1);
    status_ready = 1'b0;
    load_ir(10'h00D, c);
    chk(n_ci == 0, "R8 config-io blocked when not ready", 64'(n_ci), 64'd0);
    expect_bypass("R8 config-io not ready acts as bypass");
    status_ready = 1'b1;
    load_ir(10'h00D, c);
    chk(n_ci == 1, "R8 config-io when ready", 64'(n_ci), 64'd1);
  endtask

  task automatic t_secure();
    logic [9:0] c;
    logic [63:0] r;
    core_access = 1'b0;
    load_ir(10'h1F0, c);
    load_ir(10'h00B, c);
    chk(highz_all, "R9 pin-side lock ignored", 64'(highz_all), 64'd1);
    core_access = 1'b1;
    load_ir(10'h1F0, c);
    core_access = 1'b0;
    load_ir(10'h00B, c);
    chk(!highz_all, "R10 highz blocked when locked", 64'(highz_all), 64'd0);
    expect_bypass("R10 blocked opcode is bypass");
    n_kc = 0;
    load_ir(10'h029, c);
    chk(n_kc == 0, "R10 key clear blocked", 64'(n_kc), 64'd0);
    load_ir(10'h006, c);
    shift_dr(32, 64'h0, r);
    chk(r[31:0] == ID, "R10 IDCODE allowed when locked", r, 64'(ID));
    load_ir(10'h331, c);
    load_ir(10'h00B, c);
    chk(!highz_all, "R11 pin-side unlock ignored", 64'(highz_all), 64'd0);
    go_reset_idle();
    load_ir(10'h00B, c);
    chk(!highz_all, "R11 lock survives TLR", 64'(highz_all), 64'd0);
    core_access = 1'b1;
    load_ir(10'h331, c);
    core_access = 1'b0;
    load_ir(10'h00B, c);
    chk(highz_all, "R11 core unlock", 64'(highz_all), 64'd1);
  endtask

  task automatic t_tlr();
    logic [9:0] c;
    logic [63:0] r;
    load_ir(10'h007, c);
    go_reset_idle();
    shift_dr(32, 64'h0, r);
    chk(r[31:0] == ID, "R1 IDCODE after TLR", r, 64'(ID));
    chk(!highz_all, "R1 TLR clears highz", 64'(highz_all), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_words();
    t_bypass();
    t_boundary();
    t_hz_clamp();
    t_strobes();
    t_secure();
    t_tlr();
    idle(2);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (50000) @(posedge tck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

endmodule